// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Handshake

This block copies a block of words from one region of memory to another without the processor handling each word. Software loads a source address, a destination address and a word count through a small write-only configuration port, then sets a start bit. The engine asks the processor for the system bus and waits for a grant. It acknowledges the grant and then drives every address, read strobe and write strobe itself until the block has been moved.

Each word takes a read cycle on the bus and then a write cycle. A dead cycle between them lets the synchronous memory return the read data into a holding register. After the last write the engine drops its request and signals release. It waits for the processor to acknowledge the release, then raises a level interrupt. The interrupt stays high until software writes the clear bit. A zero count finishes at once without touching the bus.

Top module: `dma_xfer_engine`

## Requirements
- R1: Configuration writes select a register by `cfgAddr`: 0 loads the source pointer, 1 loads the destination pointer, 2 loads the word count, 3 is the command register. Bit 0 of a command write starts a transfer and bit 1 clears the interrupt.
- R2: A start with a nonzero count asserts `busReq` in the following cycle. While `busGrant` is low, `memRd` and `memWr` stay low.
- R3: The cycle after `busGrant` is first seen high, `busGrantAck` is high and no strobe is driven. The first `memRd` follows in the next cycle, at the programmed source address.
- R4: Each word is a `memRd` cycle at the source pointer, then one cycle with no strobe, then a `memWr` cycle at the destination pointer. The write carries the word that was read. Both pointers advance by one per word, and exactly `count` writes occur. `memRd` and `memWr` are never high together.
- R5: After the last write, `busReq`, `busGrantAck` and all strobes go low, and `busRelease` goes high. `busRelease` holds until `busReleaseAck` is seen and drops in the cycle after it.
- R6: `irq` rises in the same cycle that `busRelease` drops. It stays high until a command write with bit 1 set.
- R7: A start with a count of zero raises `irq` in the next cycle and never asserts `busReq`.
- R8: While a transfer is in progress, every configuration write except the interrupt clear is ignored, including a second start. The running transfer keeps its programmed pointers and count.
- R9: During and right after reset, `busReq`, `busGrantAck`, `busRelease`, `memRd`, `memWr` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgAddr | input | 2 | Configuration register select |
| cfgWrData | input | REG_W | Configuration write data |
| busReq | output | 1 | Request for the system bus |
| busGrant | input | 1 | Bus grant from the processor |
| busGrantAck | output | 1 | Grant acknowledge; high while the engine owns the bus |
| busRelease | output | 1 | Bus release indication |
| busReleaseAck | input | 1 | Processor acknowledge of the release |
| memAddr | output | AW | Memory address |
| memWrData | output | DW | Memory write data |
| memRdData | input | DW | Memory read data, valid one cycle after `memRd` |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| irq | output | 1 | Level completion interrupt |

## Verification
The assertions assume that the processor holds `busGrant` high from the moment it grants until it acknowledges the release. They also assume that memory answers a read with data in the following cycle. The strobe-requires-grant check depends on that grant discipline. The bench processor model keeps to it: it raises the grant only while a request is pending, after a chosen delay. It drops the grant only together with the release acknowledge. The memory model is a one-cycle registered array, and the source and destination regions of all transfers are kept disjoint. This keeps the expected contents of memory a pure function of the initial pattern.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK,
    ST_RD,
    ST_RWAIT,
    ST_WR,
    ST_REL
  } dmaState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic rdCycle;
    logic wrCycle;
    logic capture;
    logic advance;
    logic setIrq;
  } dmaStrobe_t;

  localparam logic [1:0] CFG_SRC = 2'd0;
  localparam logic [1:0] CFG_DST = 2'd1;
  localparam logic [1:0] CFG_CNT = 2'd2;
  localparam logic [1:0] CFG_CMD = 2'd3;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_CLEAR_BIT = 1;

endpackage

// File: rtl/dma_eng_ctrl.sv
module dma_eng_ctrl
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startHit,
  input  logic       countZero,
  input  logic       lastWord,
  input  logic       busGrant,
  input  logic       busReleaseAck,
  output dmaStrobe_t strobe,
  output logic       ctrlIdle,
  output logic       busReq,
  output logic       busGrantAck,
  output logic       busRelease
);

  dmaState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startHit && !countZero) stateNext = ST_REQ;
      ST_REQ:   if (busGrant) stateNext = ST_ACK;
      ST_ACK:   stateNext = ST_RD;
      ST_RD:    stateNext = ST_RWAIT;
      ST_RWAIT: stateNext = ST_WR;
      ST_WR:    stateNext = lastWord ? ST_REL : ST_RD;
      ST_REL:   if (busReleaseAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.rdCycle = (state == ST_RD);
    strobe.wrCycle = (state == ST_WR);
    strobe.capture = (state == ST_RWAIT);
    strobe.advance = (state == ST_WR);
    strobe.setIrq  = ((state == ST_IDLE) && startHit && countZero) ||
                     ((state == ST_REL) && busReleaseAck);
  end

  assign ctrlIdle    = (state == ST_IDLE);
  assign busReq      = (state == ST_REQ) || (state == ST_ACK) || (state == ST_RD) ||
                       (state == ST_RWAIT) || (state == ST_WR);
  assign busGrantAck = (state == ST_ACK) || (state == ST_RD) ||
                       (state == ST_RWAIT) || (state == ST_WR);
  assign busRelease  = (state == ST_REL);

endmodule

// File: rtl/dma_eng_datapath.sv
module dma_eng_datapath
  import dma_eng_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [REG_W-1:0] cfgWrData,
  input  dmaStrobe_t       strobe,
  input  logic             ctrlIdle,
  input  logic [DW-1:0]    memRdData,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWrData,
  output logic             memRd,
  output logic             memWr,
  output logic             irq,
  output logic             startHit,
  output logic             countZero,
  output logic             lastWord
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(1);
  localparam logic [CW-1:0] CNT_STEP  = CW'(1);

  logic [AW-1:0] srcPtr, dstPtr;
  logic [CW-1:0] remain;
  logic [DW-1:0] holdWord;
  logic          irqFlag;
  logic          cfgOpen, cmdWrite, clearHit;

  assign cfgOpen  = cfgWrEn && ctrlIdle;
  assign cmdWrite = cfgWrEn && (cfgAddr == CFG_CMD);
  assign startHit = cmdWrite && ctrlIdle && cfgWrData[CMD_START_BIT];
  assign clearHit = cmdWrite && cfgWrData[CMD_CLEAR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
      remain <= '0;
    end else if (strobe.advance) begin
      srcPtr <= srcPtr + ADDR_STEP;
      dstPtr <= dstPtr + ADDR_STEP;
      remain <= remain - CNT_STEP;
    end else if (cfgOpen) begin
      if (cfgAddr == CFG_SRC) srcPtr <= AW'(cfgWrData);
      if (cfgAddr == CFG_DST) dstPtr <= AW'(cfgWrData);
      if (cfgAddr == CFG_CNT) remain <= CW'(cfgWrData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdWord <= '0;
    else if (strobe.capture) holdWord <= memRdData;
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irqFlag <= 1'b0;
    else if (strobe.setIrq) irqFlag <= 1'b1;
    else if (clearHit)      irqFlag <= 1'b0;
  end

  assign countZero = (remain == '0);
  assign lastWord  = (remain == CNT_STEP);

  always_comb begin
    memAddr = '0;
    if (strobe.wrCycle)      memAddr = dstPtr;
    else if (strobe.rdCycle) memAddr = srcPtr;
  end

  assign memWrData = strobe.wrCycle ? holdWord : '0;
  assign memRd     = strobe.rdCycle;
  assign memWr     = strobe.wrCycle;
  assign irq       = irqFlag;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [REG_W-1:0] cfgWrData,
  output logic             busReq,
  input  logic             busGrant,
  output logic             busGrantAck,
  output logic             busRelease,
  input  logic             busReleaseAck,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWrData,
  input  logic [DW-1:0]    memRdData,
  output logic             memRd,
  output logic             memWr,
  output logic             irq
);

  dmaStrobe_t strobe;
  logic       ctrlIdle, startHit, countZero, lastWord;

  dma_eng_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startHit     (startHit),
    .countZero    (countZero),
    .lastWord     (lastWord),
    .busGrant     (busGrant),
    .busReleaseAck(busReleaseAck),
    .strobe       (strobe),
    .ctrlIdle     (ctrlIdle),
    .busReq       (busReq),
    .busGrantAck  (busGrantAck),
    .busRelease   (busRelease)
  );

  dma_eng_datapath #(
    .AW(AW), .DW(DW), .CW(CW), .REG_W(REG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .strobe   (strobe),
    .ctrlIdle (ctrlIdle),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memRd    (memRd),
    .memWr    (memWr),
    .irq      (irq),
    .startHit (startHit),
    .countZero(countZero),
    .lastWord (lastWord)
  );

endmodule

// File: rtl/dma_eng_chk.sv
module dma_eng_chk #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [1:0]       cfgAddr,
  input logic [REG_W-1:0] cfgWrData,
  input logic             busReq,
  input logic             busGrant,
  input logic             busGrantAck,
  input logic             busRelease,
  input logic             busReleaseAck,
  input logic [AW-1:0]    memAddr,
  input logic [DW-1:0]    memWrData,
  input logic             memRd,
  input logic             memWr,
  input logic             irq
);

  logic          wrSeen, rdSeen;
  logic [AW-1:0] prevWrAddr, prevRdAddr;
  logic          clrWrite;

  assign clrWrite = cfgWrEn && (cfgAddr == 2'd3) && cfgWrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSeen     <= 1'b0;
      rdSeen     <= 1'b0;
      prevWrAddr <= '0;
      prevRdAddr <= '0;
    end else if (busRelease) begin
      wrSeen <= 1'b0;
      rdSeen <= 1'b0;
    end else begin
      if (memWr) begin
        wrSeen     <= 1'b1;
        prevWrAddr <= memAddr;
      end
      if (memRd) begin
        rdSeen     <= 1'b1;
        prevRdAddr <= memAddr;
      end
    end
  end

  assert_no_strobe_without_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> busGrant);

  assert_ack_before_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrantAck) |-> (busGrant && !memRd && !memWr));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_read_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> (!memRd && !memWr));

  assert_wr_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && wrSeen) |-> (memAddr == prevWrAddr + AW'(1)));

  assert_rd_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && rdSeen) |-> (memAddr == prevRdAddr + AW'(1)));

  assert_release_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |-> (!busReq && !busGrantAck && !memRd && !memWr));

  assert_release_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRelease && !busReleaseAck) |=> busRelease);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWrite) |=> irq);

endmodule

bind dma_xfer_engine dma_eng_chk #(
  .AW(AW), .DW(DW), .REG_W(REG_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWrEn      (cfgWrEn),
  .cfgAddr      (cfgAddr),
  .cfgWrData    (cfgWrData),
  .busReq       (busReq),
  .busGrant     (busGrant),
  .busGrantAck  (busGrantAck),
  .busRelease   (busRelease),
  .busReleaseAck(busReleaseAck),
  .memAddr      (memAddr),
  .memWrData    (memWrData),
  .memRd        (memRd),
  .memWr        (memWr),
  .irq          (irq)
);

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int REG_W = 16;
  localparam int MEM_N = 64;
  localparam int WATCHDOG = 20000;

  // {src, dst, count, grantDelay, releaseDelay}
  localparam int NVEC = 4;
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd0,  16'd32, 16'd4, 8'd0, 8'd0},
    {16'd8,  16'd40, 16'd1, 8'd3, 8'd2},
    {16'd2,  16'd48, 16'd8, 8'd1, 8'd4},
    {16'd12, 16'd60, 16'd3, 8'd5, 8'd1}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [1:0]       cfgAddr = '0;
  logic [REG_W-1:0] cfgWrData = '0;
  logic             busReq, busGrantAck, busRelease, memRd, memWr, irq;
  logic             busGrant, busReleaseAck;
  logic [AW-1:0]    memAddr;
  logic [DW-1:0]    memWrData;
  logic [DW-1:0]    memRdData;

  logic autoProc = 1'b1;
  logic autoGrant = 1'b0, autoRelAck = 1'b0;
  logic manGrant = 1'b0, manRelAck = 1'b0;
  int   grantDelay = 0, relDelay = 0;
  int   wrPulses = 0, reqRises = 0;
  int   checks = 0, fails = 0;

  assign busGrant      = autoProc ? autoGrant  : manGrant;
  assign busReleaseAck = autoProc ? autoRelAck : manRelAck;

  always #2 clk = ~clk;

  dma_xfer_engine u_dma_xfer_engine (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .busReq(busReq), .busGrant(busGrant), .busGrantAck(busGrantAck),
    .busRelease(busRelease), .busReleaseAck(busReleaseAck),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .memRd(memRd), .memWr(memWr), .irq(irq)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 5);
  endfunction

  // synchronous memory, one-cycle read latency
  logic [DW-1:0] mem [MEM_N];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= pat(i);
      memRdData <= '0;
    end else begin
      if (memRd) memRdData <= mem[memAddr[5:0]];
      if (memWr) mem[memAddr[5:0]] <= memWrData;
    end
  end

  // processor handshake model and monitors, all at the falling edge
  initial begin
    int gCnt, rCnt;
    logic prevReq;
    gCnt = 0; rCnt = 0; prevReq = 1'b0;
    forever begin
      @(negedge clk);
      if (memWr) wrPulses++;
      if (busReq && !prevReq) reqRises++;
      prevReq = busReq;
      if (busReq && !autoGrant) begin
        if (gCnt >= grantDelay) begin autoGrant = 1'b1; gCnt = 0; end
        else gCnt++;
      end
      if (busRelease && !autoRelAck) begin
        if (rCnt >= relDelay) begin autoRelAck = 1'b1; autoGrant = 1'b0; rCnt = 0; end
        else rCnt++;
      end else if (!busRelease && autoRelAck) begin
        autoRelAck = 1'b0;
      end
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic waitIrq(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      seen = irq;
    end
  endtask

  task automatic finishUp;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finishUp();
  end

  initial begin
    logic seen;
    int w0, r0, bad, firstBad;

    // R9 reset state
    repeat (3) @(negedge clk);
    check({busReq, busGrantAck, busRelease, memRd, memWr, irq} == 6'b0, "R9",
          "outputs in reset", int'({busReq, busGrantAck, busRelease, memRd, memWr, irq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busReq, busGrantAck, busRelease, memRd, memWr, irq} == 6'b0, "R9",
          "outputs after reset", int'({busReq, busGrantAck, busRelease, memRd, memWr, irq}), 0);

    // vector table: R1 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      int src, dst, cnt;
      src = int'(VEC[v][63:48]); dst = int'(VEC[v][47:32]); cnt = int'(VEC[v][31:16]);
      grantDelay = int'(VEC[v][15:8]); relDelay = int'(VEC[v][7:0]);
      cfgWrite(2'd0, REG_W'(src));
      cfgWrite(2'd1, REG_W'(dst));
      cfgWrite(2'd2, REG_W'(cnt));
      w0 = wrPulses;
      cfgWrite(2'd3, 16'h0001);
      waitIrq(seen);
      check(seen, "R6", "irq at completion", int'(irq), 1);
      check(wrPulses - w0 == cnt, "R4", "write count", wrPulses - w0, cnt);
      bad = 0; firstBad = 0;
      for (int k = 0; k < cnt; k++)
        if (mem[dst + k] != pat(src + k)) begin
          if (bad == 0) firstBad = int'(mem[dst + k]);
          bad++;
        end
      check(bad == 0, "R4", "copied words", firstBad, int'(pat(src)));
      check(mem[dst - 1] == pat(dst - 1) && mem[dst + cnt] == pat(dst + cnt), "R1",
            "neighbours untouched", int'(mem[dst + cnt]), int'(pat(dst + cnt)));
      check(!busReq && !busRelease, "R5", "bus returned", int'({busReq, busRelease}), 0);
      repeat (3) @(negedge clk);
      check(irq == 1'b1, "R6", "irq held", int'(irq), 1);
      cfgWrite(2'd3, 16'h0002);
      check(irq == 1'b0, "R6", "irq cleared", int'(irq), 0);
    end
    grantDelay = 0; relDelay = 0;

    // R7 zero count
    r0 = reqRises;
    cfgWrite(2'd2, 16'd0);
    cfgWrite(2'd3, 16'h0001);
    check(irq == 1'b1, "R7", "irq on zero count", int'(irq), 1);
    repeat (4) @(negedge clk);
    check(reqRises == r0, "R7", "no bus request", reqRises - r0, 0);
    cfgWrite(2'd3, 16'h0002);

    // R8 writes ignored while busy
    grantDelay = 12;
    cfgWrite(2'd0, 16'd20);
    cfgWrite(2'd1, 16'd36);
    cfgWrite(2'd2, 16'd3);
    w0 = wrPulses;
    cfgWrite(2'd3, 16'h0001);
    cfgWrite(2'd2, 16'd7);
    cfgWrite(2'd0, 16'd0);
    cfgWrite(2'd3, 16'h0001);
    waitIrq(seen);
    check(wrPulses - w0 == 3, "R8", "write count with busy writes", wrPulses - w0, 3);
    check(mem[36] == pat(20) && mem[38] == pat(22) && mem[39] == pat(39), "R8",
          "busy copy data", int'(mem[36]), int'(pat(20)));
    cfgWrite(2'd3, 16'h0002);
    grantDelay = 0;

    // R2 R3 R4 R5 R6 manual handshake timing
    autoProc = 1'b0;
    cfgWrite(2'd0, 16'd24);
    cfgWrite(2'd1, 16'd44);
    cfgWrite(2'd2, 16'd2);
    cfgWrite(2'd3, 16'h0001);
    repeat (3) @(negedge clk);
    check(busReq && !memRd && !memWr && !busGrantAck, "R2", "waiting for grant",
          int'({busReq, memRd, memWr, busGrantAck}), 8);
    manGrant = 1'b1;
    @(negedge clk);
    check(busGrantAck && !memRd && !memWr, "R3", "ack cycle",
          int'({busGrantAck, memRd, memWr}), 4);
    @(negedge clk);
    check(memRd && memAddr == 16'd24, "R3", "first read address", int'(memAddr), 24);
    @(negedge clk);
    check(!memRd && !memWr, "R4", "gap cycle", int'({memRd, memWr}), 0);
    @(negedge clk);
    check(memWr && memAddr == 16'd44 && memWrData == pat(24), "R4", "first write data",
          int'(memWrData), int'(pat(24)));
    @(negedge clk);
    check(memRd && memAddr == 16'd25, "R4", "second read address", int'(memAddr), 25);
    repeat (2) @(negedge clk);
    check(memWr && memAddr == 16'd45, "R4", "second write address", int'(memAddr), 45);
    @(negedge clk);
    check(busRelease && !busReq && !busGrantAck, "R5", "release asserted",
          int'({busRelease, busReq, busGrantAck}), 4);
    repeat (3) @(negedge clk);
    check(busRelease && !irq, "R5", "release held", int'({busRelease, irq}), 2);
    manRelAck = 1'b1; manGrant = 1'b0;
    @(negedge clk);
    check(!busRelease && irq, "R6", "irq after release ack", int'({busRelease, irq}), 1);
    manRelAck = 1'b0;
    autoProc = 1'b1;

    // R6 set wins over clear during start of zero count
    cfgWrite(2'd3, 16'h0002);
    cfgWrite(2'd2, 16'd0);
    cfgWrite(2'd3, 16'h0003);
    check(irq == 1'b1, "R6", "set over clear", int'(irq), 1);

    finishUp();
  end

endmodule